// File: doc/BRIEF.md
# CAN transceiver mode controller

This block decides whether a CAN transceiver may drive the bus. A mode-select pin asks for either the driving mode (pin low) or the listen-only mode (pin high). Two supply-good flags and a receive-line watchdog can override that request. The receive-line watchdog compares the bus comparator's dominant flag with the level that the receive pin actually shows. If the bus reads dominant for too long while the receive pin stays recessive, the receive line is taken to be stuck. The block then latches a clamp fault and falls back to listen-only until the receive pin shows dominant again.

The controller is a four-state machine: OFF (supply low), SILENT, WAKE (a timed passage from SILENT to NORMAL) and NORMAL. Every transition is listed in the requirements:

- OFF→SILENT when both supplies are good.
- SILENT→WAKE when the synchronised pin is low and no clamp fault is latched.
- WAKE→NORMAL after `WAKE_CYC` cycles.
- WAKE→SILENT or NORMAL→SILENT when the pin goes high or a clamp fault is latched.
- Any state→OFF when either supply drops.

The mode pin passes through a `SYNC_STAGES`-deep synchroniser before the state machine uses it. With the defaults, the switch to NORMAL finishes 7 cycles after the pin falls. At 125 MHz this is far inside the 10 µs switching limit.

Top module: `can_xcvr_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, `mode_state` is 2'b00 (OFF), `tx_en` is 0 and `clamp_flt` is 0.
- R2: `mode_state` encodes OFF=2'b00, SILENT=2'b01, WAKE=2'b10 and NORMAL=2'b11. `tx_en` is 1 only in NORMAL, with both supplies good and no clamp fault.
- R3: With the block in NORMAL, a high mode pin moves it to SILENT at the `SYNC_STAGES`+1-th rising edge after the pin rises.
- R4: With the block in SILENT and no fault, a low mode pin enters WAKE at edge `SYNC_STAGES`+1 and NORMAL at edge `SYNC_STAGES`+1+`WAKE_CYC`. NORMAL is reached only through WAKE.
- R5: When both supplies become good while the block is in OFF, it enters SILENT at the next edge, whatever the pin level.
- R6: A mismatch sample is one with `cmp_dom`=1 and `rx_pin_lvl`=1. `clamp_flt` rises at the edge that samples the `RC_CYC`+1-th consecutive mismatch.
- R7: Any sample without a mismatch (`cmp_dom`=0 or `rx_pin_lvl`=0) restarts the mismatch count from zero.
- R8: `tx_en` falls in the same cycle that `clamp_flt` rises. While the fault is latched and the supplies are good, the state is SILENT from the next edge on, even with the pin low.
- R9: `clamp_flt` clears at the edge that samples `rx_pin_lvl`=0. It is not cleared by either supply alone dropping.
- R10: If either supply flag is low, `tx_en` is 0 at once and the state is OFF from the next edge. The mode pin has no effect until both supplies return.
- R11: When both supply flags are low (unpowered), the clamp fault, the mismatch count, the synchroniser and the state return to their reset values at the next edge.
- R12: If the clamp fault rises at the same edge that WAKE completes, `tx_en` stays 0 throughout, and the state is SILENT one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_pin | input | 1 | Asynchronous mode request: 1 = listen only, 0 = drive (an undriven pin is pulled low externally) |
| vcc_ok | input | 1 | Core supply above its undervoltage level |
| vio_ok | input | 1 | I/O supply above its undervoltage level |
| cmp_dom | input | 1 | Bus comparator reports dominant |
| rx_pin_lvl | input | 1 | Sampled receive-pin level, 0 = dominant |
| mode_state | output | 2 | Current state, encoded as in R2 |
| tx_en | output | 1 | Transmitter enable |
| clamp_flt | output | 1 | Latched receive-clamp fault |

## Verification
Two events can land on the same clock edge: completion of the WAKE count and the rise of the clamp fault. The bench provokes this by starting a continuous mismatch a computed number of cycles after the pin falls, so that both mature together. It then checks three things: the state enters NORMAL while `tx_en` stays low, the fault is set, and SILENT follows one edge later. A second overlap, an undervoltage while a fault is latched, is judged by confirming that the fault survives a single-supply drop and clears only when both supplies drop.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
    typedef enum logic [1:0] {
        MD_OFF    = 2'b00,
        MD_SILENT = 2'b01,
        MD_WAKE   = 2'b10,
        MD_NORMAL = 2'b11
    } xcvr_mode_e;
endpackage

// File: rtl/mode_pin_sync.sv
module mode_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)   ff <= '0;
                else if (clr) ff <= '0;
                else          ff <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)   ff <= '0;
                else if (clr) ff <= '0;
                else          ff <= {ff[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = ff[STAGES-1];
endmodule

// File: rtl/clamp_detect.sv
module clamp_detect #(
    parameter int RC_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic cmp_dom,
    input  logic rx_pin_lvl,
    output logic flt
);
    localparam int CW = $clog2(RC_CYC + 1);
    localparam logic [CW-1:0] CMAX = CW'(RC_CYC);

    logic [CW-1:0] cnt;
    logic          mismatch;

    // bus dominant while the receive pin still reads recessive
    assign mismatch = cmp_dom & rx_pin_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            flt <= 1'b0;
        end else if (clr) begin
            cnt <= '0;
            flt <= 1'b0;
        end else begin
            if (!rx_pin_lvl)
                flt <= 1'b0;
            else if (en && mismatch && cnt == CMAX)
                flt <= 1'b1;

            if (!en || !mismatch)
                cnt <= '0;
            else if (cnt != CMAX)
                cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
    import can_mode_pkg::*;
#(
    parameter int WAKE_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_ok,
    input  logic       sel_silent,
    input  logic       clamp,
    output xcvr_mode_e state,
    output logic       tx_en
);
    localparam int WW = (WAKE_CYC > 1) ? $clog2(WAKE_CYC) : 1;
    localparam logic [WW-1:0] WLAST = WW'(WAKE_CYC - 1);

    xcvr_mode_e    nxt;
    logic [WW-1:0] wcnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= MD_OFF;
        else        state <= nxt;
    end

    // dwell counter for the SILENT to NORMAL passage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              wcnt <= '0;
        else if (state != MD_WAKE) wcnt <= '0;
        else if (wcnt != WLAST)  wcnt <= wcnt + 1'b1;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            MD_OFF: begin
                if (pwr_ok) nxt = MD_SILENT;
            end
            MD_SILENT: begin
                if (!pwr_ok)                     nxt = MD_OFF;
                else if (!sel_silent && !clamp)  nxt = MD_WAKE;
            end
            MD_WAKE: begin
                if (!pwr_ok)                     nxt = MD_OFF;
                else if (sel_silent || clamp)    nxt = MD_SILENT;
                else if (wcnt == WLAST)          nxt = MD_NORMAL;
            end
            MD_NORMAL: begin
                if (!pwr_ok)                     nxt = MD_OFF;
                else if (sel_silent || clamp)    nxt = MD_SILENT;
            end
            default: nxt = MD_OFF;
        endcase
    end

    // outputs
    always_comb begin
        tx_en = (state == MD_NORMAL) && pwr_ok && !clamp;
    end
endmodule

// File: rtl/can_xcvr_mode_ctrl.sv
module can_xcvr_mode_ctrl
    import can_mode_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int WAKE_CYC    = 4,
    parameter int RC_CYC      = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_pin,
    input  logic       vcc_ok,
    input  logic       vio_ok,
    input  logic       cmp_dom,
    input  logic       rx_pin_lvl,
    output logic [1:0] mode_state,
    output logic       tx_en,
    output logic       clamp_flt
);
    logic       pwr_ok;
    logic       unpowered;
    logic       sel_silent;
    xcvr_mode_e st;

    assign pwr_ok    = vcc_ok & vio_ok;
    assign unpowered = ~vcc_ok & ~vio_ok;

    mode_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (unpowered),
        .d     (mode_pin),
        .q     (sel_silent)
    );

    clamp_detect #(.RC_CYC(RC_CYC)) u_clamp (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (unpowered),
        .en         (pwr_ok),
        .cmp_dom    (cmp_dom),
        .rx_pin_lvl (rx_pin_lvl),
        .flt        (clamp_flt)
    );

    mode_fsm #(.WAKE_CYC(WAKE_CYC)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_ok     (pwr_ok),
        .sel_silent (sel_silent),
        .clamp      (clamp_flt),
        .state      (st),
        .tx_en      (tx_en)
    );

    assign mode_state = st;
endmodule

// File: rtl/can_mode_ctrl_chk.sv
module can_mode_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       vcc_ok,
    input logic       vio_ok,
    input logic       cmp_dom,
    input logic       rx_pin_lvl,
    input logic [1:0] mode_state,
    input logic       tx_en,
    input logic       clamp_flt
);
    a_r2_tx_needs_normal: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |-> (mode_state == 2'b11 && !clamp_flt));

    a_r4_normal_via_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_state != 2'b10 && mode_state != 2'b11) |=> (mode_state != 2'b11));

    a_r6_clamp_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clamp_flt) |-> $past(cmp_dom && rx_pin_lvl));

    a_r8_clamp_silences: assert property (@(posedge clk) disable iff (!rst_n)
        (clamp_flt && vcc_ok && vio_ok) |=> (mode_state == 2'b01));

    a_r9_clamp_release: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_pin_lvl |=> !clamp_flt);

    a_r10_uv_enters_off: assert property (@(posedge clk) disable iff (!rst_n)
        !(vcc_ok && vio_ok) |=> (mode_state == 2'b00));

    a_r11_unpowered_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!vcc_ok && !vio_ok) |=> !clamp_flt);
endmodule

bind can_xcvr_mode_ctrl can_mode_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .vcc_ok     (vcc_ok),
    .vio_ok     (vio_ok),
    .cmp_dom    (cmp_dom),
    .rx_pin_lvl (rx_pin_lvl),
    .mode_state (mode_state),
    .tx_en      (tx_en),
    .clamp_flt  (clamp_flt)
);

// File: tb/sim_can_xcvr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_can_xcvr_mode_ctrl;
    localparam int SYNC = 2;
    localparam int WAKE = 4;
    localparam int RC   = 5;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       mode_pin, vcc_ok, vio_ok, cmp_dom, rx_pin_lvl;
    logic [1:0] mode_state;
    logic       tx_en, clamp_flt;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    can_xcvr_mode_ctrl #(.SYNC_STAGES(SYNC), .WAKE_CYC(WAKE), .RC_CYC(RC)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_pin(mode_pin), .vcc_ok(vcc_ok),
        .vio_ok(vio_ok), .cmp_dom(cmp_dom), .rx_pin_lvl(rx_pin_lvl),
        .mode_state(mode_state), .tx_en(tx_en), .clamp_flt(clamp_flt)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag, input int st, input int tx, input int cf);
        chk({tag, " state"}, int'(mode_state), st);
        chk({tag, " tx_en"}, int'(tx_en), tx);
        chk({tag, " clamp"}, int'(clamp_flt), cf);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", nchk + 1, nfail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; mode_pin = 1; vcc_ok = 0; vio_ok = 0; cmp_dom = 0; rx_pin_lvl = 1;
        step(3);
        chk_all("R1 reset", 0, 0, 0);
        rst_n = 1;
        step(2);
        chk("R10 unpowered stays OFF", int'(mode_state), 0);

        // R5: supplies return with pin high
        vcc_ok = 1; vio_ok = 1;
        step(1);
        chk_all("R5 power-up to SILENT", 1, 0, 0);
        step(3);
        chk("R3 pin high holds SILENT", int'(mode_state), 1);

        // R4: wake sweep edge by edge
        mode_pin = 0;
        for (int k = 1; k <= SYNC + 1 + WAKE; k++) begin
            int e;
            step(1);
            e = (k <= SYNC) ? 1 : (k <= SYNC + WAKE) ? 2 : 3;
            chk($sformatf("R4 wake edge %0d state", k), int'(mode_state), e);
            chk($sformatf("R2 wake edge %0d tx", k), int'(tx_en), (e == 3) ? 1 : 0);
        end

        // R3: NORMAL to SILENT
        mode_pin = 1;
        for (int k = 1; k <= SYNC + 1; k++) begin
            step(1);
            chk($sformatf("R3 leave edge %0d", k), int'(mode_state), (k <= SYNC) ? 3 : 1);
        end
        mode_pin = 0;
        step(SYNC + 1 + WAKE);
        chk("R4 back to NORMAL", int'(mode_state), 3);

        // R6/R8/R9: clamp length sweep
        for (int L = 1; L <= RC + 3; L++) begin
            cmp_dom = 1; rx_pin_lvl = 1;
            step(L);
            chk($sformatf("R6 mismatch len %0d", L), int'(clamp_flt), (L > RC) ? 1 : 0);
            chk($sformatf("R8 tx len %0d", L), int'(tx_en), (L > RC) ? 0 : 1);
            if (L >= RC + 2)
                chk($sformatf("R8 forced SILENT len %0d", L), int'(mode_state), 1);
            cmp_dom = 0; rx_pin_lvl = 0;
            step(1);
            chk($sformatf("R9 release len %0d", L), int'(clamp_flt), 0);
            rx_pin_lvl = 1;
            step(WAKE + 3);
            chk($sformatf("R9 recovers len %0d", L), int'(mode_state), 3);
        end

        // R7: interrupted mismatch, comparator gap then receive-pin gap
        cmp_dom = 1; rx_pin_lvl = 1;
        step(RC);
        cmp_dom = 0;
        step(1);
        cmp_dom = 1;
        step(RC);
        chk("R7 comparator gap restarts", int'(clamp_flt), 0);
        rx_pin_lvl = 0;
        step(1);
        rx_pin_lvl = 1;
        step(RC);
        chk("R7 rx gap restarts", int'(clamp_flt), 0);
        step(1);
        chk("R6 fault after full run", int'(clamp_flt), 1);

        // R8: fault blocks wake with pin low
        step(10);
        chk_all("R8 fault holds SILENT", 1, 0, 1);

        // R10/R9: single supply drop keeps the fault, pin ignored
        vcc_ok = 0;
        step(1);
        chk_all("R10 vcc low OFF", 0, 0, 1);
        mode_pin = 1; step(4); mode_pin = 0; step(4);
        chk("R10 pin ignored in OFF", int'(mode_state), 0);
        vcc_ok = 1;
        step(1);
        chk_all("R9 fault kept over vcc drop", 1, 0, 1);

        // R11: both supplies low clears the fault
        vcc_ok = 0; vio_ok = 0;
        step(1);
        chk_all("R11 unpowered clears", 0, 0, 0);
        cmp_dom = 0; vcc_ok = 1; vio_ok = 1;
        step(1);
        chk("R5 repower SILENT", int'(mode_state), 1);
        step(WAKE + 2);
        chk("R4 repower reaches NORMAL", int'(mode_state), 3);

        // R10: transmitter drops in the same cycle as the supply
        vio_ok = 0;
        #1;
        chk("R10 tx drops at once", int'(tx_en), 0);
        step(1);
        chk("R10 vio low OFF", int'(mode_state), 0);
        vio_ok = 1;
        step(1);

        // R12: wake completion and clamp rise on the same edge
        mode_pin = 1;
        step(SYNC + 2);
        chk("R12 setup SILENT", int'(mode_state), 1);
        mode_pin = 0;
        step(SYNC + WAKE - RC);
        cmp_dom = 1; rx_pin_lvl = 1;
        for (int k = SYNC + WAKE - RC + 1; k <= SYNC + 1 + WAKE; k++) begin
            step(1);
            chk($sformatf("R12 tx edge %0d", k), int'(tx_en), 0);
        end
        chk("R12 NORMAL at coincidence", int'(mode_state), 3);
        chk("R12 fault at coincidence", int'(clamp_flt), 1);
        step(1);
        chk_all("R12 SILENT after", 1, 0, 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule